// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches and jumps while they sit in the decode stage of a five-stage in-order pipeline. The taken-or-not decision does not wait for the ALU. A dedicated equality comparator XORs the two operands bit by bit, ORs the differences together and inverts the result. An ALU result from the instruction now in the memory stage can be forwarded into either comparator input.

The unit watches the destinations of older instructions in the execute and memory stages. When the branch cannot yet see a value it needs, the unit stalls. An ALU producer directly ahead costs one stall, because one cycle later its result can be forwarded. A load directly ahead costs two stalls, and a load two instructions ahead costs one. Once a producer reaches write-back, the register file's write-then-read behaviour delivers the value, so no forwarding from write-back exists.

On a taken branch or a jump, the unit sends the program counter to the computed target and flushes the fetched instruction into a no-op, which costs one bubble. During a stall, the PC and IF/ID hold and ID/EX receives zeroed control.

Top module: `brz_branch_unit`

## Requirements
- R1: A branch-if-equal (`id_is_branch`=1, `id_br_ne`=0) is taken exactly when its two compared operands are equal. A branch-if-not-equal (`id_br_ne`=1) is taken exactly when they differ.
- R2: The first compared operand is `mem_alu_result` instead of `id_rs_data` when all of these hold: a branch is decoding, `mem_wr`=1, `mem_is_load`=0, `mem_dst` is nonzero and `mem_dst` equals `id_rs`.
- R3: Under the same conditions with `mem_dst` equal to `id_rt`, the second compared operand is `mem_alu_result` instead of `id_rt_data`.
- R4: No other source is forwarded. When the memory stage does not write (`mem_wr`=0), the register-file data is compared.
- R5: `stall` is 1 while a branch is decoding and the execute-stage instruction writes (`ex_wr`=1) a nonzero `ex_dst` equal to `id_rs` or `id_rt`. This gives one stall behind an ALU producer and two behind a load.
- R6: `stall` is 1 while a branch is decoding and a load in the memory stage (`mem_wr`=1, `mem_is_load`=1) writes a nonzero `mem_dst` equal to `id_rs` or `id_rt`.
- R7: A jump, or a taken branch that is not stalled, gives `flush`=1. `flush` is never 1 while `stall`=1. A stalled branch gives `pc_sel`=00.
- R8: `pc_sel` encodes 00 for sequential, 01 for branch target and 10 for jump target. For a branch, `target` = `id_pc_plus4` + (sign-extended `id_imm` shifted left by 2).
- R9: For a jump, `pc_sel`=10 and `target` = {upper 4 bits of `id_pc_plus4`, `id_jidx`, 2'b00}. A jump never stalls.
- R10: Register 0 never causes a stall and is never forwarded.
- R11: A branch that is not taken gives `flush`=0 and `pc_sel`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded properties |
| rst_n | input | 1 | Active-low reset that gates the properties |
| id_is_branch | input | 1 | A conditional branch is decoding |
| id_br_ne | input | 1 | The branch is branch-if-not-equal |
| id_is_jump | input | 1 | A jump is decoding |
| id_rs | input | 5 | First source register index |
| id_rt | input | 5 | Second source register index |
| id_rs_data | input | 32 | Register-file data for id_rs |
| id_rt_data | input | 32 | Register-file data for id_rt |
| id_pc_plus4 | input | 32 | Address of the branch plus 4 |
| id_imm | input | 16 | Branch word offset |
| id_jidx | input | 26 | Jump word index |
| ex_dst | input | 5 | Destination of the execute-stage instruction |
| ex_wr | input | 1 | The execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination of the memory-stage instruction |
| mem_wr | input | 1 | The memory-stage instruction writes a register |
| mem_is_load | input | 1 | The memory-stage instruction is a load |
| mem_alu_result | input | 32 | ALU result held in the memory stage |
| stall | output | 1 | Hold PC and IF/ID, and bubble ID/EX |
| flush | output | 1 | Zero the instruction in IF/ID |
| pc_sel | output | 2 | Next-PC source |
| target | output | 32 | Branch or jump target address |

## Verification
Every result of this unit is combinational from its inputs in the same cycle: stall, flush, PC select and target all settle before the next edge. The bench therefore drives each stimulus just after a rising edge and samples half a period later, before the following edge. Multi-cycle stall counts are checked by stepping the producer through the execute, memory and write-back positions on consecutive cycles and counting the cycles in which `stall` is sampled high.

// File: rtl/brz_pkg.sv
package brz_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ = 2'b00,
    PCS_BR  = 2'b01,
    PCS_JMP = 2'b10
  } pc_src_e;
endpackage

// File: rtl/brz_eq_cmp.sv
module brz_eq_cmp #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            eq
);
  logic [XLEN-1:0] diff;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign diff[i] = a[i] ^ b[i];
  end

  assign eq = ~(|diff);

  p_eq_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eq |-> (a == b));
  p_ne_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eq |-> (a != b));
endmodule

// File: rtl/brz_operand_fwd.sv
module brz_operand_fwd #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [RIDX-1:0] src_idx,
  input  logic [XLEN-1:0] rf_data,
  input  logic [RIDX-1:0] fwd_dst,
  input  logic            fwd_wr,
  input  logic            fwd_is_load,
  input  logic [XLEN-1:0] fwd_data,
  output logic [XLEN-1:0] opnd
);
  logic take_fwd;

  always_comb begin
    take_fwd = en && fwd_wr && !fwd_is_load
               && (fwd_dst != '0) && (fwd_dst == src_idx);
    opnd     = take_fwd ? fwd_data : rf_data;
  end

  // R10: register 0 never forwarded
  p_no_zero_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == '0) |-> (opnd == rf_data));
  // R4: idle memory stage leaves register-file data in place
  p_no_idle_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_wr |-> (opnd == rf_data));
endmodule

// File: rtl/brz_hazard_det.sv
module brz_hazard_det #(
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [RIDX-1:0] rs,
  input  logic [RIDX-1:0] rt,
  input  logic [RIDX-1:0] ex_dst,
  input  logic            ex_wr,
  input  logic [RIDX-1:0] mem_dst,
  input  logic            mem_wr,
  input  logic            mem_is_load,
  output logic            stall
);
  logic ex_hit;
  logic mem_hit;

  always_comb begin
    ex_hit  = ex_wr && (ex_dst != '0) && ((ex_dst == rs) || (ex_dst == rt));
    mem_hit = mem_wr && mem_is_load && (mem_dst != '0)
              && ((mem_dst == rs) || (mem_dst == rt));
    stall   = en && (ex_hit || mem_hit);
  end

  p_stall_needs_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> en);
  p_stall_needs_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_wr || mem_wr));
endmodule

// File: rtl/brz_branch_unit.sv
module brz_branch_unit #(
  parameter int XLEN  = 32,
  parameter int RIDX  = 5,
  parameter int OFFW  = 16,
  parameter int JIDXW = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_is_branch,
  input  logic             id_br_ne,
  input  logic             id_is_jump,
  input  logic [RIDX-1:0]  id_rs,
  input  logic [RIDX-1:0]  id_rt,
  input  logic [XLEN-1:0]  id_rs_data,
  input  logic [XLEN-1:0]  id_rt_data,
  input  logic [XLEN-1:0]  id_pc_plus4,
  input  logic [OFFW-1:0]  id_imm,
  input  logic [JIDXW-1:0] id_jidx,
  input  logic [RIDX-1:0]  ex_dst,
  input  logic             ex_wr,
  input  logic [RIDX-1:0]  mem_dst,
  input  logic             mem_wr,
  input  logic             mem_is_load,
  input  logic [XLEN-1:0]  mem_alu_result,
  output logic             stall,
  output logic             flush,
  output logic [1:0]       pc_sel,
  output logic [XLEN-1:0]  target
);
  import brz_pkg::*;

  localparam int PC_HI = XLEN - JIDXW - 2;
  localparam int SEXT  = XLEN - OFFW - 2;
  localparam int NOPND = 2;

  logic [RIDX-1:0] src_idx [NOPND];
  logic [XLEN-1:0] src_rf  [NOPND];
  logic [XLEN-1:0] opnd    [NOPND];
  logic            eq;
  logic            br_go;
  logic            br_stall;
  logic            is_br;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] j_tgt;
  pc_src_e         sel_q;

  assign is_br      = id_is_branch && !id_is_jump;
  assign src_idx[0] = id_rs;
  assign src_idx[1] = id_rt;
  assign src_rf[0]  = id_rs_data;
  assign src_rf[1]  = id_rt_data;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    brz_operand_fwd #(.XLEN(XLEN), .RIDX(RIDX)) u_fwd (
      .clk(clk), .rst_n(rst_n), .en(is_br),
      .src_idx(src_idx[g]), .rf_data(src_rf[g]),
      .fwd_dst(mem_dst), .fwd_wr(mem_wr), .fwd_is_load(mem_is_load),
      .fwd_data(mem_alu_result), .opnd(opnd[g])
    );
  end

  brz_eq_cmp #(.XLEN(XLEN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .a(opnd[0]), .b(opnd[1]), .eq(eq)
  );

  brz_hazard_det #(.RIDX(RIDX)) u_haz (
    .clk(clk), .rst_n(rst_n), .en(is_br), .rs(id_rs), .rt(id_rt),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .mem_is_load(mem_is_load), .stall(br_stall)
  );

  always_comb begin
    br_tgt = id_pc_plus4 + {{SEXT{id_imm[OFFW-1]}}, id_imm, 2'b00};
    j_tgt  = {id_pc_plus4[XLEN-1 -: PC_HI], id_jidx, 2'b00};
    br_go  = is_br && !br_stall && (eq ^ id_br_ne);
    if (id_is_jump)  sel_q = PCS_JMP;
    else if (br_go)  sel_q = PCS_BR;
    else             sel_q = PCS_SEQ;
  end

  assign stall  = br_stall;
  assign flush  = id_is_jump || br_go;
  assign pc_sel = sel_q;
  assign target = id_is_jump ? j_tgt : br_tgt;

  p_no_flush_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!flush && pc_sel == PCS_SEQ));
  p_jump_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_is_jump |-> (flush && !stall && pc_sel == PCS_JMP
                    && target[1:0] == 2'b00
                    && target[XLEN-1 -: PC_HI] == id_pc_plus4[XLEN-1 -: PC_HI]));
  p_flush_means_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (pc_sel != PCS_SEQ));
  p_zero_never_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0 && id_rt == '0) |-> !stall);
endmodule

// File: tb/sim_brz_branch_unit.sv
module sim_brz_branch_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_is_branch, id_br_ne, id_is_jump;
  logic [4:0]  id_rs, id_rt, ex_dst, mem_dst;
  logic [31:0] id_rs_data, id_rt_data, id_pc_plus4, mem_alu_result;
  logic [15:0] id_imm;
  logic [25:0] id_jidx;
  logic        ex_wr, mem_wr, mem_is_load;
  logic        stall, flush;
  logic [1:0]  pc_sel;
  logic [31:0] target;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  brz_branch_unit u0 (.*);

  typedef struct packed {
    logic        br, ne, jmp;
    logic [4:0]  rs, rt;
    logic [31:0] rsd, rtd;
    logic [4:0]  exd;
    logic        exw;
    logic [4:0]  memd;
    logic        memw, meml;
    logic [31:0] memr;
    logic        e_stall, e_flush;
    logic [1:0]  e_sel;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1 beq, equal operands -> taken
    '{1,0,0, 1,2, 5,5, 0,0, 0,0,0, 0, 0,1,2'b01},
    // R1 R11 beq, unequal -> not taken
    '{1,0,0, 1,2, 5,6, 0,0, 0,0,0, 0, 0,0,2'b00},
    // R1 bne, unequal -> taken
    '{1,1,0, 1,2, 5,6, 0,0, 0,0,0, 0, 0,1,2'b01},
    // R1 R11 bne, equal -> not taken
    '{1,1,0, 1,2, 9,9, 0,0, 0,0,0, 0, 0,0,2'b00},
    // R2 rs forwarded from memory-stage ALU result
    '{1,0,0, 3,2, 1,7, 0,0, 3,1,0, 7, 0,1,2'b01},
    // R3 rt forwarded from memory-stage ALU result
    '{1,0,0, 1,4, 1,9, 0,0, 4,1,0, 1, 0,1,2'b01},
    // R4 memory stage idle: register-file data used
    '{1,0,0, 3,2, 1,7, 0,0, 3,0,0, 7, 0,0,2'b00},
    // R5 ALU in execute writes rs -> stall, no redirect
    '{1,0,0, 1,2, 5,5, 1,1, 0,0,0, 0, 1,0,2'b00},
    // R5 execute writes rt (load or ALU alike)
    '{1,0,0, 1,2, 5,5, 2,1, 0,0,0, 0, 1,0,2'b00},
    // R6 load in memory stage writes rs -> stall
    '{1,0,0, 1,2, 5,5, 0,0, 1,1,1, 0, 1,0,2'b00},
    // R10 execute writes r0, branch reads r0: no stall
    '{1,0,0, 0,0, 4,4, 0,1, 0,0,0, 0, 0,1,2'b01},
    // R10 memory dst r0 not forwarded
    '{1,0,0, 0,2, 2,2, 0,0, 0,1,0, 7, 0,1,2'b01},
    // R9 jump ignores hazards on its fields
    '{0,0,1, 1,2, 5,6, 1,1, 2,1,1, 0, 0,1,2'b10},
    // R5 matching dst without write: no stall
    '{1,0,0, 1,2, 5,6, 1,0, 2,0,1, 0, 0,0,2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_is_branch = 0; id_br_ne = 0; id_is_jump = 0;
    id_rs = 0; id_rt = 0; id_rs_data = 0; id_rt_data = 0;
    id_pc_plus4 = 0; id_imm = 0; id_jidx = 0;
    ex_dst = 0; ex_wr = 0; mem_dst = 0; mem_wr = 0; mem_is_load = 0;
    mem_alu_result = 0;
  endtask

  // place a branch on r1/r2 with equal data, producer writing r1
  task automatic step_producer(input int pos, input bit is_load, output bit s);
    @(posedge clk);
    idle();
    id_is_branch = 1; id_rs = 1; id_rt = 2; id_rs_data = 3; id_rt_data = 3;
    if (pos == 0) begin ex_dst = 1; ex_wr = 1; end
    else if (pos == 1) begin mem_dst = 1; mem_wr = 1; mem_is_load = is_load; end
    #(PERIOD/2);
    s = stall;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #(PERIOD/2);
    // reset state, quiet inputs: R7 R11
    chk("R7 reset flush", {31'b0, flush}, 32'd0);
    chk("R5 reset stall", {31'b0, stall}, 32'd0);
    chk("R11 reset pc_sel", {30'b0, pc_sel}, 32'd0);
    @(posedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      id_is_branch = VECS[i].br; id_br_ne = VECS[i].ne; id_is_jump = VECS[i].jmp;
      id_rs = VECS[i].rs; id_rt = VECS[i].rt;
      id_rs_data = VECS[i].rsd; id_rt_data = VECS[i].rtd;
      ex_dst = VECS[i].exd; ex_wr = VECS[i].exw;
      mem_dst = VECS[i].memd; mem_wr = VECS[i].memw; mem_is_load = VECS[i].meml;
      mem_alu_result = VECS[i].memr;
      #(PERIOD/2);
      chk($sformatf("R5/R6 vec%0d stall", i), {31'b0, stall}, {31'b0, VECS[i].e_stall});
      chk($sformatf("R7 vec%0d flush", i), {31'b0, flush}, {31'b0, VECS[i].e_flush});
      chk($sformatf("R8 vec%0d pc_sel", i), {30'b0, pc_sel}, {30'b0, VECS[i].e_sel});
    end

    // R8 branch target, negative and positive offsets
    @(posedge clk); idle();
    id_is_branch = 1; id_rs = 1; id_rt = 2; id_pc_plus4 = 32'h0000_1000;
    id_imm = 16'hFFFF;
    #(PERIOD/2);
    chk("R8 target negative", target, 32'h0000_0FFC);
    @(posedge clk); id_imm = 16'h0010;
    #(PERIOD/2);
    chk("R8 target positive", target, 32'h0000_1040);

    // R9 jump target
    @(posedge clk); idle();
    id_is_jump = 1; id_pc_plus4 = 32'hA000_0004; id_jidx = 26'h000_0123;
    #(PERIOD/2);
    chk("R9 jump target", target, 32'hA000_048C);
    chk("R9 jump sel", {30'b0, pc_sel}, 32'd2);

    // R5 stall counts: producer walks execute -> memory -> write-back
    begin
      bit s; int cnt;
      cnt = 0;
      for (int p = 0; p < 3; p++) begin step_producer(p, 1'b0, s); cnt += s; end
      chk("R5 ALU producer stall count", cnt, 1);
      cnt = 0;
      for (int p = 0; p < 3; p++) begin step_producer(p, 1'b1, s); cnt += s; end
      chk("R5 load producer stall count", cnt, 2);
      cnt = 0;
      for (int p = 1; p < 3; p++) begin step_producer(p, 1'b1, s); cnt += s; end
      chk("R6 load two back stall count", cnt, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule